// File: doc/BRIEF.md
# Indexed Shadow-Memory Configuration Block

This block sits on a narrow I/O slave bus of a PC-class chipset. Software first writes a register number to an index port. It then reads or writes that register through a data port. This gives access to a 256-byte configuration file. Two more I/O ports each hold a free-standing scratch byte.

Three of the configuration bytes drive hardware directly. One turns on an external-cache enable line. One holds the write-protect and BIOS-shadow mode bits. One holds a per-segment enable mask for eight 16 KB segments that cover 0xD0000 to 0xEFFFF. A combinational lookup port takes a 20-bit memory address and reports three things: whether a read at that address is served by on-board DRAM, whether a write lands in DRAM, and whether the write is thrown away. The memory controller uses this routing to steer each CPU access.

Top module: `shadow_cfg_ctrl`

## Requirements
- R1: A write to I/O address 0x0022 stores the 8-bit register index. A write to 0x0024 stores the data byte into the configuration register that the index selects. A read of 0x0024 returns that register. Other registers and the index are left unchanged.
- R2: After reset, every configuration register reads 0x00, the index is 0x00, and both scratch bytes read 0xFF.
- R3: `io_rdata` is 0xFF whenever `io_rd` is low, and whenever the address is not one of 0x0024, 0x00E1 or 0x00E2. The index port 0x0022 is write-only and also reads 0xFF.
- R4: Addresses 0x00E1 and 0x00E2 are two independent scratch bytes. Each reads back its own last written value, and a write to one leaves the other unchanged.
- R5: The route outputs are `mem_rd_dram`, `mem_wr_dram` and `mem_wr_drop`, each active high. For addresses in 0xD0000 + i*0x4000 (i = 0..7), bit i of register 0x23 enables the segment. An enabled segment reports `mem_rd_dram`=1.
- R6: The write-protect bit for an enabled segment below 0xE0000 is bit 4 of register 0x22. For an enabled segment from 0xE0000 to 0xEFFFF it is bit 3. When the protect bit is set, the outputs are `mem_wr_dram`=0 and `mem_wr_drop`=1. When it is clear, they are `mem_wr_dram`=1 and `mem_wr_drop`=0.
- R7: A segment in 0xD0000 to 0xEFFFF whose enable bit is 0 reports all three route outputs as 0, so both reads and writes go to the external bus.
- R8: For 0xF0000 to 0xFFFFF, bit 7 of register 0x22 selects shadowing. When set, the outputs are read external (`mem_rd_dram`=0) and write DRAM (`mem_wr_dram`=1). When clear, both reads and writes go to DRAM. `mem_wr_drop` is 0 in both cases.
- R9: Addresses below 0xD0000 report all three route outputs as 0.
- R10: `ext_cache_en` equals bit 4 of register 0x21.
- R11: The effect of a configuration write appears on the route and cache outputs on the cycle after the clock edge that takes the write. Before that edge the outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | Write strobe, one access per cycle in which it is high |
| io_rd | input | 1 | Read strobe, qualifies `io_rdata` |
| io_rdata | output | 8 | Combinational read data |
| mem_addr | input | 20 | Memory address to classify |
| mem_rd_dram | output | 1 | Read at `mem_addr` is served by on-board DRAM |
| mem_wr_dram | output | 1 | Write at `mem_addr` lands in on-board DRAM |
| mem_wr_drop | output | 1 | Write at `mem_addr` is discarded (protected shadow) |
| ext_cache_en | output | 1 | External cache enable |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that the I/O inputs hold steady across each clock edge. The bench keeps within these limits: it drives each access on a falling edge and raises only one strobe per access. It also starts no I/O traffic until a few cycles after reset is released, so the internal reset synchronizer has already let go. Memory lookups are plain combinational queries and need no such care. The random phase therefore mixes arbitrary configuration values with addresses across 0xC0000 to 0xFFFFF, and the directed cases cover the 0xCFFFF/0xD0000, 0xDFFFF/0xE0000 and 0xEFFFF/0xF0000 edges.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;

  // I/O port map
  localparam logic [15:0] PORT_INDEX = 16'h0022;
  localparam logic [15:0] PORT_DATA  = 16'h0024;
  localparam logic [15:0] PORT_SCR0  = 16'h00E1;

  // Configuration register numbers that feed hardware
  localparam logic [7:0] REG_CACHE = 8'h21;
  localparam logic [7:0] REG_MODE  = 8'h22;
  localparam logic [7:0] REG_SEGEN = 8'h23;

  // Bit positions inside those registers
  localparam int BIT_CACHE = 4;
  localparam int BIT_BIOS  = 7;
  localparam int BIT_WP_LO = 4;
  localparam int BIT_WP_HI = 3;

  typedef struct packed {
    logic rd_dram;
    logic wr_dram;
    logic wr_drop;
  } route_t;

  typedef struct packed {
    logic [7:0] cache;
    logic [7:0] mode;
    logic [7:0] segen;
  } ctl_t;

endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_cfg_pkg::*;
#(
  parameter int NREG = 256,
  parameter int DW   = 8,
  parameter int AW   = 16,
  parameter int NSCR = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic [DW-1:0] io_wdata,
  input  logic          io_wr,
  input  logic          io_rd,
  output logic [DW-1:0] io_rdata,
  output ctl_t          ctl
);

  localparam int IDX_W = $clog2(NREG);

  logic [IDX_W-1:0]          idx_q;
  logic [IDX_W-1:0]          idx_d;
  logic                      idx_en;
  logic                      hit_idx;
  logic                      hit_data;
  logic [NSCR-1:0]           hit_scr;
  logic [NREG-1:0][DW-1:0]   regs_flat;
  logic [NSCR-1:0][DW-1:0]   scr_flat;

  // Port decode
  always_comb begin
    hit_idx  = (io_addr == PORT_INDEX);
    hit_data = (io_addr == PORT_DATA);
    for (int s = 0; s < NSCR; s++) begin
      hit_scr[s] = (io_addr == (PORT_SCR0 + AW'(s)));
    end
  end

  // Index register: next state
  always_comb begin
    idx_en = io_wr && hit_idx;
    idx_d  = idx_en ? io_wdata[IDX_W-1:0] : idx_q;
  end

  // Index register: state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // Configuration file, one enabled byte per entry
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic          en;
    logic [DW-1:0] q;
    logic [DW-1:0] d;
    always_comb begin
      en = io_wr && hit_data && (idx_q == IDX_W'(k));
      d  = en ? io_wdata : q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign regs_flat[k] = q;
  end

  // Scratch bytes
  for (genvar s = 0; s < NSCR; s++) begin : g_scr
    logic          en;
    logic [DW-1:0] q;
    logic [DW-1:0] d;
    always_comb begin
      en = io_wr && hit_scr[s];
      d  = en ? io_wdata : q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '1;
      else        q <= d;
    end
    assign scr_flat[s] = q;
  end

  // Read mux
  always_comb begin
    io_rdata = '1;
    if (io_rd) begin
      if (hit_data) io_rdata = regs_flat[idx_q];
      for (int s = 0; s < NSCR; s++) begin
        if (hit_scr[s]) io_rdata = scr_flat[s];
      end
    end
  end

  // Hardware-facing bytes
  always_comb begin
    ctl.cache = regs_flat[REG_CACHE];
    ctl.mode  = regs_flat[REG_MODE];
    ctl.segen = regs_flat[REG_SEGEN];
  end

endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode
  import shadow_cfg_pkg::*;
#(
  parameter int              MEM_AW    = 20,
  parameter int              SEG_W     = 14,
  parameter int              NSEG      = 8,
  parameter int              SPLIT     = 4,
  parameter logic [19:0]     SEG_BASE  = 20'hD0000,
  parameter logic [19:0]     BIOS_BASE = 20'hF0000,
  parameter int              BIOS_W    = 16
) (
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic [NSEG-1:0]   seg_en,
  input  logic              wp_lo,
  input  logic              wp_hi,
  input  logic              bios_shadow,
  output route_t            route
);

  localparam int            SI_W    = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam logic [MEM_AW:0] SEG_LO = (MEM_AW+1)'(SEG_BASE);
  localparam logic [MEM_AW:0] SEG_HI = SEG_LO + ((MEM_AW+1)'(NSEG) << SEG_W);

  logic [MEM_AW-1:0] seg_off;
  logic [SI_W-1:0]   seg_idx;
  logic              in_seg;
  logic              in_bios;
  route_t            seg_route [NSEG];

  always_comb begin
    in_seg  = ({1'b0, mem_addr} >= SEG_LO) && ({1'b0, mem_addr} < SEG_HI);
    seg_off = mem_addr - MEM_AW'(SEG_BASE);
    seg_idx = seg_off[SEG_W +: SI_W];
    in_bios = (mem_addr[MEM_AW-1:BIOS_W] == BIOS_BASE[MEM_AW-1:BIOS_W]);
  end

  // Per-segment routing; the lower group and upper group take different protect bits
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic wp;
    if (i < SPLIT) begin : g_lo
      assign wp = wp_lo;
    end else begin : g_hi
      assign wp = wp_hi;
    end
    always_comb begin
      seg_route[i].rd_dram = seg_en[i];
      seg_route[i].wr_dram = seg_en[i] & ~wp;
      seg_route[i].wr_drop = seg_en[i] &  wp;
    end
  end

  always_comb begin
    route = '0;
    if (in_bios) begin
      route.rd_dram = ~bios_shadow;
      route.wr_dram = 1'b1;
    end else if (in_seg) begin
      route = seg_route[seg_idx];
    end
  end

endmodule

// File: rtl/shadow_cfg_ctrl.sv
module shadow_cfg_ctrl
  import shadow_cfg_pkg::*;
#(
  parameter int NREG   = 256,
  parameter int MEM_AW = 20,
  parameter int NSEG   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd_dram,
  output logic              mem_wr_dram,
  output logic              mem_wr_drop,
  output logic              ext_cache_en
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  ctl_t       ctl;
  route_t     route;

  // Reset asserts asynchronously, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  shadow_cfg_regs #(
    .NREG (NREG),
    .DW   (8),
    .AW   (16),
    .NSCR (2)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_rdata (io_rdata),
    .ctl      (ctl)
  );

  shadow_seg_decode #(
    .MEM_AW (MEM_AW),
    .NSEG   (NSEG)
  ) u_dec (
    .mem_addr    (mem_addr),
    .seg_en      (ctl.segen[NSEG-1:0]),
    .wp_lo       (ctl.mode[BIT_WP_LO]),
    .wp_hi       (ctl.mode[BIT_WP_HI]),
    .bios_shadow (ctl.mode[BIT_BIOS]),
    .route       (route)
  );

  assign mem_rd_dram  = route.rd_dram;
  assign mem_wr_dram  = route.wr_dram;
  assign mem_wr_drop  = route.wr_drop;
  assign ext_cache_en = ctl.cache[BIT_CACHE];

endmodule

// File: rtl/shadow_cfg_chk.sv
module shadow_cfg_chk #(
  parameter int MEM_AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       io_addr,
  input logic [7:0]        io_wdata,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_rdata,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              mem_rd_dram,
  input logic              mem_wr_dram,
  input logic              mem_wr_drop,
  input logic              ext_cache_en
);

  // R3
  no_decode_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_rd || !(io_addr == 16'h0024 || io_addr == 16'h00E1 || io_addr == 16'h00E2))
      |-> (io_rdata == 8'hFF));

  // R4
  scratch_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 16'h00E1) ##1 (io_rd && io_addr == 16'h00E1)
      |-> (io_rdata == $past(io_wdata)));

  // R6
  drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_drop |-> (mem_rd_dram && !mem_wr_dram));

  // R8
  bios_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr >= MEM_AW'(20'hF0000)) |-> (mem_wr_dram && !mem_wr_drop));

  // R9
  low_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr < MEM_AW'(20'hD0000)) |-> (!mem_rd_dram && !mem_wr_dram && !mem_wr_drop));

  // R11
  cache_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == 16'h0024) |=> $stable(ext_cache_en));

endmodule

bind shadow_cfg_ctrl shadow_cfg_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_addr      (io_addr),
  .io_wdata     (io_wdata),
  .io_wr        (io_wr),
  .io_rd        (io_rd),
  .io_rdata     (io_rdata),
  .mem_addr     (mem_addr),
  .mem_rd_dram  (mem_rd_dram),
  .mem_wr_dram  (mem_wr_dram),
  .mem_wr_drop  (mem_wr_drop),
  .ext_cache_en (ext_cache_en)
);

// File: tb/shadow_cfg_ctrl_tb.sv
module shadow_cfg_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr;
  logic        mem_rd_dram;
  logic        mem_wr_dram;
  logic        mem_wr_drop;
  logic        ext_cache_en;

  int checks;
  int failures;
  bit done;

  logic [7:0] m_regs [256];
  logic [7:0] m_scr  [2];
  logic [7:0] m_idx;

  shadow_cfg_ctrl dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_addr      (io_addr),
    .io_wdata     (io_wdata),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_rdata     (io_rdata),
    .mem_addr     (mem_addr),
    .mem_rd_dram  (mem_rd_dram),
    .mem_wr_dram  (mem_wr_dram),
    .mem_wr_drop  (mem_wr_drop),
    .ext_cache_en (ext_cache_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [2:0] exp_route(logic [19:0] a, logic [7:0] mode, logic [7:0] segen);
    logic [2:0] r;
    int         seg;
    logic       wp;
    r = 3'b000;
    if (a >= 20'hF0000) begin
      r = mode[7] ? 3'b010 : 3'b110;
    end else if (a >= 20'hD0000) begin
      seg = int'((a - 20'hD0000) >> 14);
      wp  = (a < 20'hE0000) ? mode[4] : mode[3];
      if (segen[seg]) r = wp ? 3'b101 : 3'b110;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr  = a;
    io_wdata = d;
    io_wr    = 1'b1;
    @(negedge clk);
    io_wr    = 1'b0;
    if (a == 16'h0022) m_idx = d;
    else if (a == 16'h0024) m_regs[m_idx] = d;
    else if (a == 16'h00E1) m_scr[0] = d;
    else if (a == 16'h00E2) m_scr[1] = d;
  endtask

  task automatic io_read_chk(string req, logic [15:0] a, logic [7:0] exp);
    @(negedge clk);
    io_addr = a;
    io_rd   = 1'b1;
    #1;
    check(req, 32'(io_rdata), 32'(exp));
    io_rd   = 1'b0;
  endtask

  task automatic cfg_write(logic [7:0] r, logic [7:0] v);
    io_write(16'h0022, r);
    io_write(16'h0024, v);
  endtask

  task automatic look_chk(string req, logic [19:0] a);
    mem_addr = a;
    #1;
    check(req, 32'({mem_rd_dram, mem_wr_dram, mem_wr_drop}),
          32'(exp_route(a, m_regs[8'h22], m_regs[8'h23])));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [19:0] a;
    checks = 0; failures = 0; done = 1'b0;
    for (int i = 0; i < 256; i++) m_regs[i] = 8'h00;
    m_scr[0] = 8'hFF; m_scr[1] = 8'hFF; m_idx = 8'h00;
    rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_wr = 1'b0; io_rd = 1'b0; mem_addr = '0;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    io_read_chk("R2 reg0", 16'h0024, 8'h00);
    io_read_chk("R2 scr0", 16'h00E1, 8'hFF);
    io_read_chk("R2 scr1", 16'h00E2, 8'hFF);
    #1 check("R2 cache", 32'(ext_cache_en), 32'd0);
    look_chk("R2 D-seg", 20'hD4000);
    look_chk("R2 bios", 20'hF8000);

    // R3 undecoded and idle reads
    io_read_chk("R3 index port", 16'h0022, 8'hFF);
    io_read_chk("R3 other port", 16'h0023, 8'hFF);
    @(negedge clk); io_addr = 16'h00E1; io_rd = 1'b0; #1;
    check("R3 rd low", 32'(io_rdata), 32'hFF);

    // R1 index/data access, neighbours untouched
    cfg_write(8'h40, 8'hA5);
    cfg_write(8'h41, 8'h3C);
    io_write(16'h0022, 8'h40);
    io_read_chk("R1 readback 40", 16'h0024, 8'hA5);
    io_write(16'h0022, 8'h41);
    io_read_chk("R1 readback 41", 16'h0024, 8'h3C);
    io_write(16'h0022, 8'h3F);
    io_read_chk("R1 neighbour", 16'h0024, 8'h00);

    // R4 scratch independence
    io_write(16'h00E1, 8'h12);
    io_read_chk("R4 scr0", 16'h00E1, 8'h12);
    io_read_chk("R4 scr1 kept", 16'h00E2, 8'hFF);
    io_write(16'h00E2, 8'h9A);
    io_read_chk("R4 scr1", 16'h00E2, 8'h9A);
    io_read_chk("R4 scr0 kept", 16'h00E1, 8'h12);

    // R10 cache enable
    cfg_write(8'h21, 8'h10);
    #1 check("R10 cache on", 32'(ext_cache_en), 32'd1);
    cfg_write(8'h21, 8'hEF);
    #1 check("R10 cache off", 32'(ext_cache_en), 32'd0);

    // R11 timing: lookup changes only after the edge that takes the write
    io_write(16'h0022, 8'h23);
    @(negedge clk);
    mem_addr = 20'hD0000; io_addr = 16'h0024; io_wdata = 8'h01; io_wr = 1'b1; #1;
    check("R11 before edge", 32'({mem_rd_dram, mem_wr_dram, mem_wr_drop}), 32'b000);
    @(negedge clk); io_wr = 1'b0; m_regs[8'h23] = 8'h01; #1;
    check("R11 after edge", 32'({mem_rd_dram, mem_wr_dram, mem_wr_drop}), 32'b110);

    // R5/R6/R7 boundaries with mixed protect bits
    cfg_write(8'h23, 8'h18);            // segments 3 and 4 enabled
    cfg_write(8'h22, 8'h10);            // low half protected
    look_chk("R5 R6 DFFFF protected", 20'hDFFFF);
    look_chk("R5 R6 E0000 writable", 20'hE0000);
    look_chk("R7 DBFFF disabled", 20'hDBFFF);
    look_chk("R7 E4000 disabled", 20'hE4000);
    cfg_write(8'h22, 8'h08);            // high half protected
    look_chk("R6 DFFFF writable", 20'hDFFFF);
    look_chk("R6 E0000 protected", 20'hE0000);
    cfg_write(8'h23, 8'hFF);
    look_chk("R5 EFFFF", 20'hEFFFF);
    look_chk("R5 D0000", 20'hD0000);

    // R8 BIOS modes, R9 below window
    look_chk("R8 bios unshadowed", 20'hF0000);
    cfg_write(8'h22, 8'h80);
    look_chk("R8 bios shadowed", 20'hFFFFF);
    look_chk("R9 CFFFF", 20'hCFFFF);
    look_chk("R9 zero", 20'h00000);

    // Random mix
    for (int it = 0; it < 150; it++) begin
      v = 8'($urandom);
      case ($urandom % 4)
        0: cfg_write(8'h22, v);
        1: cfg_write(8'h23, v);
        2: cfg_write(8'h21, v);
        default: cfg_write(8'($urandom), v);
      endcase
      #1 check("R10 random", 32'(ext_cache_en), 32'(m_regs[8'h21][4]));
      for (int j = 0; j < 4; j++) begin
        a = 20'hC0000 + 20'($urandom % 32'h40000);
        look_chk("R5 R6 R7 R8 R9 random", a);
      end
      if (it % 10 == 0) begin
        io_write(16'h0022, 8'($urandom));
        io_read_chk("R1 random readback", 16'h0024, m_regs[m_idx]);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule